// File: doc/BRIEF.md
# Trip Recovery Policy Sequencer

This block decides when a protected power channel is switched on or off after a protection event. Upstream sensing logic raises two requests: one saying that a limit has been reached, and one saying that an energy or power budget is exceeded. The sequencer moves the channel through four phases: normal running, limiting, tripped, and a recovery policy. It drives the channel enable together with a power-good flag that is high when the channel is good and a fault flag that is high when there is a fault.

Three recovery policies are selected through a two-bit input:

- **Auto-retry** waits a fixed retry period and then switches the channel back on.
- **Hiccup** first waits a cool-down interval and then the retry period before switching back on.
- **Latch-off** keeps the channel off until an external reset arrives.

All intervals are counted in millisecond ticks supplied from outside. A retry counter limits how many automatic restarts are made in one session. When that cap is hit, the sequencer latches off and raises a latch flag. The counter clears on the external reset, or once the channel has run cleanly for a programmable stable time.

Top module: `trip_policy_seq`

## Requirements
- R1: After reset, chan_en=1, pwr_good=1, fault=0, retry_cnt=0 and latched=0.
- R2: While running normally, limit_hit=1 moves the block to the limiting phase one clock later: chan_en stays 1, pwr_good=0 and fault=0. When limit_hit falls, pwr_good returns to 1 one clock later.
- R3: budget_over=1 while the channel is on (normal or limiting) gives chan_en=0, pwr_good=0 and fault=1 one clock later.
- R4: With policy 2'b00 (auto-retry), the channel stays off with fault=1 until the retry_ms-th ms_tick counted in the waiting phase. It is then re-enabled (chan_en=1, pwr_good=1, fault=0) and retry_cnt increases by one.
- R5: With policy 2'b01 (hiccup), the channel stays off for cool_ms ticks and then for a further retry_ms ticks before it is re-enabled, and retry_cnt increases by one.
- R6: With policy 2'b10 or 2'b11 (latch-off), a trip sets latched=1 and keeps chan_en=0 and fault=1 whatever ms_tick does. retry_cnt is left unchanged.
- R7: A trip under policy 2'b00 or 2'b01 when retry_cnt is already equal to or above max_retry latches the channel off (latched=1) instead of retrying.
- R8: sys_reset=1 while latched re-enables the channel one clock later, with latched=0 and retry_cnt=0.
- R9: After the channel has stayed in normal running for stable_ms ms_ticks, retry_cnt clears to 0. Before that tick, it keeps its value.
- R10: budget_over and limit_hit have no effect while the channel is off waiting in cool-down or retry.
- R11: An interval programmed as 0 ends on the first ms_tick, the same as an interval of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| limit_hit | input | 1 | A current, voltage or power limit is reached |
| budget_over | input | 1 | Energy or power budget exceeded; trip request |
| policy | input | 2 | 00 auto-retry, 01 hiccup, 1x latch-off |
| retry_ms | input | TW | Retry wait in ticks |
| cool_ms | input | TW | Hiccup cool-down in ticks |
| stable_ms | input | TW | Clean run time that clears the retry count |
| max_retry | input | CW | Retry cap |
| sys_reset | input | 1 | External release of a latch; clears the retry count |
| chan_en | output | 1 | Channel enable |
| pwr_good | output | 1 | High when power is good |
| fault | output | 1 | High when in fault |
| retry_cnt | output | CW | Retries in the current session |
| latched | output | 1 | Channel latched off |

## Verification
Each result falls on a fixed edge:

- The phase outputs (enable, power-good, fault, latch) change on the first clock edge that samples a request or a sys_reset.
- The phase after a trip (waiting or latched) is in place one edge later.
- A wait ends on the very edge that samples its last counted ms_tick. The retry count changes on that same edge.

The bench drives every input on the falling edge and issues each tick as a pulse spanning exactly one rising edge. It checks on the falling edge that follows the edge where a result is due. It also checks one tick early, to prove that no result arrives before its time.

// File: rtl/trip_policy_seq.sv
module trip_policy_seq #(
  parameter int TW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          limit_hit,
  input  logic          budget_over,
  input  logic [1:0]    policy,
  input  logic [TW-1:0] retry_ms,
  input  logic [TW-1:0] cool_ms,
  input  logic [TW-1:0] stable_ms,
  input  logic [CW-1:0] max_retry,
  input  logic          sys_reset,
  output logic          chan_en,
  output logic          pwr_good,
  output logic          fault,
  output logic [CW-1:0] retry_cnt,
  output logic          latched
);

  typedef enum logic [2:0] {S_RUN, S_LIM, S_TRIP, S_COOL, S_HOLD, S_LATCH} st_t;

  st_t           st, st_n;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] lim;
  logic          done;

  assign lim  = (st == S_COOL) ? cool_ms : (st == S_HOLD) ? retry_ms : stable_ms;
  assign done = ms_tick && (({1'b0, tcnt} + 1'b1) >= {1'b0, lim});

  always_comb begin
    st_n = st;
    case (st)
      S_RUN:   if (budget_over) st_n = S_TRIP;
               else if (limit_hit) st_n = S_LIM;
      S_LIM:   if (budget_over) st_n = S_TRIP;
               else if (!limit_hit) st_n = S_RUN;
      S_TRIP:  if (policy[1] || retry_cnt >= max_retry) st_n = S_LATCH;
               else if (policy[0]) st_n = S_COOL;
               else st_n = S_HOLD;
      S_COOL:  if (done) st_n = S_HOLD;
      S_HOLD:  if (done) st_n = S_RUN;
      S_LATCH: if (sys_reset) st_n = S_RUN;
      default: st_n = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      tcnt      <= '0;
      retry_cnt <= '0;
    end else begin
      st <= st_n;
      if (st_n != st) tcnt <= '0;
      else if (ms_tick && tcnt != '1) tcnt <= tcnt + 1'b1;

      if (sys_reset) retry_cnt <= '0;
      else if (st == S_HOLD && done && retry_cnt != '1) retry_cnt <= retry_cnt + 1'b1;
      else if (st == S_RUN && done) retry_cnt <= '0;
    end
  end

  assign chan_en  = (st == S_RUN) || (st == S_LIM);
  assign pwr_good = (st == S_RUN);
  assign fault    = (st == S_TRIP) || (st == S_COOL) || (st == S_HOLD) || (st == S_LATCH);
  assign latched  = (st == S_LATCH);

  AST_TRIP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    budget_over && chan_en |=> !chan_en && fault); // R3
  AST_REENABLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_en) |-> ($past(st) == S_HOLD || $past(st) == S_LATCH)); // R4
  AST_LATCH_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TRIP && policy[1] |=> latched); // R6
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !sys_reset |=> latched && !chan_en); // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    latched && sys_reset |=> chan_en && retry_cnt == '0); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt != $past(retry_cnt) |-> (retry_cnt == '0 || retry_cnt == $past(retry_cnt) + 1'b1)); // R9
  AST_WAIT_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COOL || st == S_HOLD) && !ms_tick |=> !chan_en); // R10

endmodule

// File: tb/test_trip_policy_seq.sv
module test_trip_policy_seq;
  localparam int TW = 16;
  localparam int CW = 4;

  logic          clk = 0, rst_n = 0, ms_tick = 0, limit_hit = 0, budget_over = 0, sys_reset = 0;
  logic [1:0]    policy = 2'b00;
  logic [TW-1:0] retry_ms = 3, cool_ms = 2, stable_ms = 5;
  logic [CW-1:0] max_retry = 2;
  logic          chan_en, pwr_good, fault, latched;
  logic [CW-1:0] retry_cnt;
  int            total = 0, bad = 0;
  bit            done_flag = 0;

  always #10 clk = ~clk;

  trip_policy_seq #(.TW(TW), .CW(CW)) i_trip_policy_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .limit_hit(limit_hit),
    .budget_over(budget_over), .policy(policy), .retry_ms(retry_ms), .cool_ms(cool_ms),
    .stable_ms(stable_ms), .max_retry(max_retry), .sys_reset(sys_reset),
    .chan_en(chan_en), .pwr_good(pwr_good), .fault(fault), .retry_cnt(retry_cnt), .latched(latched));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic state_is(input string tag, input int en, input int pg, input int fl, input int lt);
    chk({tag, " en"}, chan_en, en);
    chk({tag, " pg"}, pwr_good, pg);
    chk({tag, " fault"}, fault, fl);
    chk({tag, " latched"}, latched, lt);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    limit_hit = 0; budget_over = 0; sys_reset = 0; ms_tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1;
      @(negedge clk) ms_tick = 0;
    end
  endtask

  task automatic trip(input string tag);
    budget_over = 1;
    @(negedge clk) budget_over = 0;
    state_is({tag, " R3 trip"}, 0, 0, 1, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    state_is("R1 reset", 1, 1, 0, 0);
    chk("R1 cnt", retry_cnt, 0);
  endtask

  task automatic t_limit();
    do_reset();
    limit_hit = 1;
    @(negedge clk);
    state_is("R2 limit", 1, 0, 0, 0);
    limit_hit = 0;
    @(negedge clk);
    state_is("R2 back", 1, 1, 0, 0);
    limit_hit = 1;
    @(negedge clk);
    policy = 2'b10;
    trip("R3 from limit");
    limit_hit = 0;
  endtask

  task automatic t_auto();
    do_reset();
    policy = 2'b00;
    trip("R4");
    budget_over = 1; limit_hit = 1;
    tick(2);
    state_is("R10 wait ignores", 0, 0, 1, 0);
    budget_over = 0; limit_hit = 0;
    tick(1);
    state_is("R4 reenable", 1, 1, 0, 0);
    chk("R4 cnt", retry_cnt, 1);
  endtask

  task automatic t_hiccup();
    do_reset();
    policy = 2'b01;
    trip("R5");
    tick(4);
    state_is("R5 still cooling", 0, 0, 1, 0);
    tick(1);
    state_is("R5 reenable", 1, 1, 0, 0);
    chk("R5 cnt", retry_cnt, 1);
  endtask

  task automatic t_cap();
    do_reset();
    policy = 2'b00;
    for (int k = 0; k < 2; k++) begin
      trip("R7 loop");
      tick(3);
    end
    chk("R7 cnt at cap", retry_cnt, 2);
    trip("R7 capped");
    state_is("R7 latched", 0, 0, 1, 1);
    tick(8);
    state_is("R7 stays", 0, 0, 1, 1);
    sys_reset = 1;
    @(negedge clk) sys_reset = 0;
    state_is("R8 release", 1, 1, 0, 0);
    chk("R8 cnt", retry_cnt, 0);
  endtask

  task automatic t_latch();
    do_reset();
    policy = 2'b11;
    trip("R6");
    state_is("R6 latched", 0, 0, 1, 1);
    tick(6);
    state_is("R6 stays", 0, 0, 1, 1);
    chk("R6 cnt", retry_cnt, 0);
  endtask

  task automatic t_stable();
    do_reset();
    policy = 2'b00;
    trip("R9");
    tick(3);
    chk("R9 cnt set", retry_cnt, 1);
    tick(4);
    chk("R9 cnt held", retry_cnt, 1);
    tick(1);
    chk("R9 cnt cleared", retry_cnt, 0);
  endtask

  task automatic t_zero();
    do_reset();
    policy = 2'b00;
    retry_ms = 0;
    trip("R11");
    @(negedge clk);
    state_is("R11 waits for tick", 0, 0, 1, 0);
    tick(1);
    state_is("R11 reenable", 1, 1, 0, 0);
    retry_ms = 3;
  endtask

  initial begin
    t_reset();
    t_limit();
    t_auto();
    t_hiccup();
    t_cap();
    t_latch();
    t_stable();
    t_zero();
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule